// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns pairs of parallel audio samples into a single serial data line. It frames the data with a bit clock and a word-select line. Each frame holds 64 bit-clock periods. Word select is low for the left half and high for the right half, and each half carries one sample of up to 24 bits, most significant bit first. Two justifications are available at run time. In the standard inter-IC sound placement the most significant bit trails the word-select change by one bit. In the left-justified placement it shares the bit period that starts with the change. Every unused slot is driven low.

The bit clock and word select come from one of two places. As clock master, the block derives them from its own system clock and drives them out. As a slave, it takes them from external pins through a synchronizer. Samples arrive with a one-cycle valid strobe. They wait in a pending register and move into the active holding pair at the start of each frame. If no new sample came, the previous pair is sent again.

After power-down is released, the line stays low for a programmable number of frames while the upstream filters settle. The default is 12288 frames. A ready flag then rises. The mute sequencer has three named states:
- `MUTE_OFF`: powered down, with the count cleared.
- `MUTE_WAIT`: counting word-select rising edges.
- `MUTE_LIVE`: data enabled.

The transitions are:
- OFF→WAIT when power-down drops.
- WAIT→LIVE on the last counted rising edge.
- WAIT→OFF and LIVE→OFF whenever power-down is raised.

Top module: `stereo_ser_tx`

## Requirements
- R1: In master mode (`master_mode`=1), `bclk_out` has a period of 2·BCLK_HALF system clocks, and `ws_out` changes only on a falling edge of `bclk_out`, once every HALF_BITS (32) bit periods.
- R2: `sdata` changes only one system clock after a bit-clock falling edge, except when it is forced low by power-down.
- R3: With `fmt_sel`=0 (standard placement), slot 0 of a half-frame is low, slots 1..24 carry sample bits 23..0, and slots 25..31 are low. Slot 0 is the bit period that begins with the word-select change.
- R4: With `fmt_sel`=1 (left-justified), slots 0..23 carry sample bits 23..0 and slots 24..31 are low. The most significant bit is driven on the same falling edge on which word select changes.
- R5: The half with word select 0 carries the left sample, and the half with word select 1 carries the right sample.
- R6: A pair presented with `smp_valid` is sent starting at the next left half (a word-select falling edge). If no new pair arrives before a frame start, the previous pair is repeated.
- R7: While `pwr_down`=1, `sdata` and `ready` are low one clock later, and the mute count is cleared.
- R8: After `pwr_down` falls, `sdata` stays low and `ready` stays low until MUTE_FRAMES word-select rising edges have been seen. `ready` rises at that rising edge and then stays high until power-down. Data is enabled from the next bit period.
- R9: In slave mode (`master_mode`=0), the bit clock and word select come from `bclk_in`/`ws_in` through a SYNC_STAGES-flop synchronizer, and `bclk_out` and `ws_out` are held low.
- R10: After reset, `sdata`, `ready`, `bclk_out` and `ws_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_down | input | 1 | Power-down request, active high |
| master_mode | input | 1 | 1 = generate bit clock and word select, 0 = take them from pins |
| fmt_sel | input | 1 | 0 = standard placement, 1 = left-justified |
| bclk_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| smp_valid | input | 1 | One-cycle strobe for a new sample pair |
| smp_left | input | SAMPLE_W | Left sample |
| smp_right | input | SAMPLE_W | Right sample |
| bclk_out | output | 1 | Generated bit clock (low in slave mode) |
| ws_out | output | 1 | Generated word select (low in slave mode) |
| sdata | output | 1 | Serial data |
| ready | output | 1 | Post-power-down mute has expired |

## Verification
The bound checker covers the cycle-level rules on every clock:
- word select moves only with a bit-clock fall in master mode;
- serial data moves only in the cycle after a bit-slot boundary;
- power-down silences the line and the flag within one clock;
- the line is low whenever `ready` was low;
- `ready` rises only at a right-half boundary.

Only the bench's scenarios can show the rest:
- where each sample bit lands in each format;
- that the left and right halves carry the right samples;
- that samples are captured or repeated at frame starts;
- the exact length of the mute window and its restart after a second power-down;
- that slave timing taken from external pins gives the same stream.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

    typedef enum logic [1:0] {
        MUTE_OFF  = 2'd0,
        MUTE_WAIT = 2'd1,
        MUTE_LIVE = 2'd2
    } mute_state_e;

    typedef enum logic {
        FMT_STD  = 1'b0,
        FMT_LEFT = 1'b1
    } fmt_e;

    // One bit-slot boundary as seen by the serializer
    typedef struct packed {
        logic fall;
        logic ws;
    } slot_evt_t;

endpackage

// File: rtl/sstx_mclk.sv
module sstx_mclk #(
    parameter int BCLK_HALF = 2,
    parameter int HALF_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic ws,
    output logic fall_stb
);
    localparam int HC_W  = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
    localparam int FRAME = 2 * HALF_BITS;
    localparam int BC_W  = $clog2(FRAME);

    logic [HC_W-1:0] half_cnt;
    logic [BC_W-1:0] bit_cnt;
    logic [BC_W-1:0] bit_nxt;

    always_comb begin
        if (bit_cnt == BC_W'(FRAME - 1))
            bit_nxt = '0;
        else
            bit_nxt = bit_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bclk     <= 1'b0;
            bit_cnt  <= '0;
            ws       <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            fall_stb <= 1'b0;
            if (half_cnt == HC_W'(BCLK_HALF - 1)) begin
                half_cnt <= '0;
                bclk     <= ~bclk;
                if (bclk) begin
                    bit_cnt  <= bit_nxt;
                    ws       <= (int'(bit_nxt) >= HALF_BITS);
                    fall_stb <= 1'b1;
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sstx_sync.sv
module sstx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_pin,
    input  logic ws_pin,
    output logic ws,
    output logic fall_stb
);
    logic [STAGES-1:0] b_sh;
    logic [STAGES-1:0] w_sh;
    logic              b_last;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_sh[g] <= 1'b0;
                w_sh[g] <= 1'b0;
            end else if (g == 0) begin
                b_sh[g] <= bclk_pin;
                w_sh[g] <= ws_pin;
            end else begin
                b_sh[g] <= b_sh[(g > 0) ? g - 1 : 0];
                w_sh[g] <= w_sh[(g > 0) ? g - 1 : 0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_last <= 1'b0;
        else        b_last <= b_sh[STAGES-1];
    end

    assign fall_stb = b_last & ~b_sh[STAGES-1];
    assign ws       = w_sh[STAGES-1];

endmodule

// File: rtl/sstx_mute.sv
module sstx_mute
    import sstx_pkg::*;
#(
    parameter int MUTE_FRAMES = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic ws_rise,
    output logic ready
);
    localparam int CNT_W = $clog2(MUTE_FRAMES + 1);

    mute_state_e      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            MUTE_OFF: begin
                cnt_nxt = '0;
                if (!pwr_down) state_nxt = MUTE_WAIT;
            end
            MUTE_WAIT: begin
                if (pwr_down) begin
                    state_nxt = MUTE_OFF;
                    cnt_nxt   = '0;
                end else if (ws_rise) begin
                    if (cnt == CNT_W'(MUTE_FRAMES - 1)) begin
                        state_nxt = MUTE_LIVE;
                        cnt_nxt   = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            end
            MUTE_LIVE: begin
                if (pwr_down) state_nxt = MUTE_OFF;
            end
            default: begin
                state_nxt = MUTE_OFF;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MUTE_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        ready = (state == MUTE_LIVE);
    end

endmodule

// File: rtl/sstx_shift.sv
module sstx_shift
    import sstx_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int HALF_BITS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  slot_evt_t           evt,
    input  fmt_e                fmt,
    input  logic                force_low,
    input  logic                enable,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                ws_rise,
    output logic                sdata
);
    localparam int SLOT_W = $clog2(HALF_BITS);

    logic                ws_last;
    logic [SLOT_W-1:0]   slot, slot_nxt;
    logic [SAMPLE_W-1:0] hold_l, hold_r, pend_l, pend_r;
    logic [SAMPLE_W-1:0] hold_l_nxt, hold_r_nxt, word_nxt;
    logic                pend_v;
    logic                ws_chg, left_start, bit_nxt;

    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] w,
                                      input logic [SLOT_W-1:0]   s,
                                      input fmt_e                f);
        int idx;
        idx = int'(s) - ((f == FMT_STD) ? 1 : 0);
        if (idx >= 0 && idx < SAMPLE_W)
            return w[SAMPLE_W-1-idx];
        return 1'b0;
    endfunction

    assign ws_chg     = evt.fall && (evt.ws != ws_last);
    assign left_start = ws_chg && !evt.ws;
    assign ws_rise    = ws_chg && evt.ws;

    always_comb begin
        if (ws_chg)
            slot_nxt = '0;
        else if (slot == SLOT_W'(HALF_BITS - 1))
            slot_nxt = slot;
        else
            slot_nxt = slot + 1'b1;

        hold_l_nxt = (left_start && pend_v) ? pend_l : hold_l;
        hold_r_nxt = (left_start && pend_v) ? pend_r : hold_r;
        word_nxt   = evt.ws ? hold_r_nxt : hold_l_nxt;
        bit_nxt    = enable ? pick_bit(word_nxt, slot_nxt, fmt) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_last <= 1'b0;
            slot    <= SLOT_W'(HALF_BITS - 1);
            hold_l  <= '0;
            hold_r  <= '0;
        end else if (evt.fall) begin
            ws_last <= evt.ws;
            slot    <= slot_nxt;
            hold_l  <= hold_l_nxt;
            hold_r  <= hold_r_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_l <= '0;
            pend_r <= '0;
            pend_v <= 1'b0;
        end else if (smp_valid) begin
            pend_l <= smp_left;
            pend_r <= smp_right;
            pend_v <= 1'b1;
        end else if (left_start) begin
            pend_v <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sdata <= 1'b0;
        else if (force_low) sdata <= 1'b0;
        else if (evt.fall)  sdata <= bit_nxt;
    end

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
    import sstx_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int HALF_BITS   = 32,
    parameter int BCLK_HALF   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MUTE_FRAMES = 12288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_down,
    input  logic                master_mode,
    input  logic                fmt_sel,
    input  logic                bclk_in,
    input  logic                ws_in,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                bclk_out,
    output logic                ws_out,
    output logic                sdata,
    output logic                ready
);
    logic      m_bclk, m_ws, m_fall;
    logic      s_ws, s_fall;
    logic      sel_fall, sel_ws, ws_rise;
    slot_evt_t evt;

    sstx_mclk #(.BCLK_HALF(BCLK_HALF), .HALF_BITS(HALF_BITS)) i_mclk (
        .clk(clk), .rst_n(rst_n), .bclk(m_bclk), .ws(m_ws), .fall_stb(m_fall)
    );

    sstx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .bclk_pin(bclk_in), .ws_pin(ws_in),
        .ws(s_ws), .fall_stb(s_fall)
    );

    assign sel_fall = master_mode ? m_fall : s_fall;
    assign sel_ws   = master_mode ? m_ws   : s_ws;
    assign evt      = '{fall: sel_fall, ws: sel_ws};
    assign bclk_out = master_mode & m_bclk;
    assign ws_out   = master_mode & m_ws;

    sstx_mute #(.MUTE_FRAMES(MUTE_FRAMES)) i_mute (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ws_rise(ws_rise),
        .ready(ready)
    );

    sstx_shift #(.SAMPLE_W(SAMPLE_W), .HALF_BITS(HALF_BITS)) i_shift (
        .clk(clk), .rst_n(rst_n), .evt(evt), .fmt(fmt_e'(fmt_sel)),
        .force_low(pwr_down), .enable(ready), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .ws_rise(ws_rise),
        .sdata(sdata)
    );

endmodule

// File: rtl/sstx_chk.sv
module sstx_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_down,
    input logic master,
    input logic bclk_out,
    input logic ws_out,
    input logic sdata,
    input logic ready,
    input logic fall_stb,
    input logic src_ws
);
    AST_WS_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (master && $past(master) && $changed(ws_out)) |-> $fell(bclk_out)); // R1

    AST_SDATA_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down && !$past(pwr_down) && $changed(sdata)) |-> $past(fall_stb)); // R2

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!sdata && !ready)); // R7

    AST_MUTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ready) |-> !sdata); // R8

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !pwr_down) |=> ready); // R8

    AST_READY_AT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(fall_stb) && $past(src_ws))); // R8

endmodule

bind stereo_ser_tx sstx_chk i_chk (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .master(master_mode),
    .bclk_out(bclk_out), .ws_out(ws_out), .sdata(sdata), .ready(ready),
    .fall_stb(sel_fall), .src_ws(sel_ws)
);

// File: tb/test_stereo_ser_tx.sv
module test_stereo_ser_tx;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 24;
    localparam int HB         = 32;
    localparam int BH         = 2;
    localparam int MF         = 3;
    localparam int SL_HALF    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_b = 1'b1, master_b = 1'b1, fmt_b = 1'b0;
    logic bclk_in = 1'b0, ws_in = 1'b0, smp_valid = 1'b0;
    logic [W-1:0] smp_left = '0, smp_right = '0;
    logic bclk_out, ws_out, sdata, ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    stereo_ser_tx #(.SAMPLE_W(W), .HALF_BITS(HB), .BCLK_HALF(BH),
                    .SYNC_STAGES(2), .MUTE_FRAMES(MF)) i_stereo_ser_tx (
        .clk(clk), .rst_n(rst_n), .pwr_down(pd_b), .master_mode(master_b),
        .fmt_sel(fmt_b), .bclk_in(bclk_in), .ws_in(ws_in),
        .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
        .bclk_out(bclk_out), .ws_out(ws_out), .sdata(sdata), .ready(ready)
    );

    int errors = 0, checks = 0, cyc = 0, last_rise = -1, n_ws_chg = 0;
    bit done = 0;

    // reference model state
    logic m_ws_last = 0, m_ready = 0, pend_v = 0;
    int   m_slot = HB - 1, m_rise = 0;
    logic [W-1:0] hold_l = '0, hold_r = '0, pend_l = '0, pend_r = '0;
    logic [W-1:0] q_l[$], q_r[$];
    logic obs_prev = 0, mb_prev = 0, fell_last = 0, sd_prev = 0, pd_prev = 1;
    int   sg_cnt = 0, sg_bit = 2*HB - 1;
    bit   just_obs = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic observe();
        logic w, expb;
        logic [W-1:0] word;
        int idx;
        w = master_b ? ws_out : ws_in;
        if (master_b) begin
            if (last_rise >= 0)
                chk((cyc - last_rise) == 2*BH, "R1", "bit clock period", cyc - last_rise, 2*BH);
            last_rise = cyc;
        end else begin
            chk(bclk_out == 1'b0 && ws_out == 1'b0, "R9", "master outputs in slave mode",
                {bclk_out, ws_out}, 0);
        end
        if (w != m_ws_last) begin
            if (master_b && n_ws_chg > 0)
                chk(m_slot == HB - 1, "R1", "slots per half before word select change", m_slot + 1, HB);
            n_ws_chg++;
            m_slot = 0;
            if (!w && pend_v) begin
                hold_l = pend_l; hold_r = pend_r; pend_v = 0;
            end
        end else if (m_slot < HB - 1) begin
            m_slot++;
        end
        word = w ? hold_r : hold_l;
        idx  = m_slot - (fmt_b ? 0 : 1);
        if (pd_b || !m_ready)         expb = 1'b0;
        else if (idx >= 0 && idx < W) expb = word[W-1-idx];
        else                          expb = 1'b0;
        if (pd_b)
            chk(sdata === expb, "R7", "sdata in power-down", sdata, expb);
        else if (!m_ready)
            chk(sdata === expb, "R8", "sdata during mute", sdata, expb);
        else
            chk(sdata === expb, fmt_b ? "R4 R5 R6" : "R3 R5 R6", "sdata bit", sdata, expb);
        if (w != m_ws_last && w && !pd_b && !m_ready) begin
            m_rise++;
            if (m_rise == MF) m_ready = 1;
        end
        m_ws_last = w;
        chk(ready === m_ready, pd_b ? "R7" : "R8", "ready flag", ready, m_ready);
        if (!w && m_slot == 2 && q_l.size() > 0) begin
            smp_left  = q_l.pop_front();
            smp_right = q_r.pop_front();
            smp_valid = 1'b1;
            pend_l = smp_left; pend_r = smp_right; pend_v = 1;
        end
    endtask

    task automatic tick();
        logic obs_b, fell_now;
        @(negedge clk);
        cyc++;
        just_obs  = 0;
        smp_valid = 1'b0;
        if (!master_b) begin
            sg_cnt++;
            if (sg_cnt == SL_HALF) begin
                sg_cnt  = 0;
                bclk_in = ~bclk_in;
                if (!bclk_in) begin
                    sg_bit = (sg_bit + 1) % (2*HB);
                    ws_in  = (sg_bit >= HB);
                end
            end
        end
        obs_b = master_b ? bclk_out : bclk_in;
        if (master_b) begin
            fell_now = mb_prev && !bclk_out;
            if (!pd_b && !pd_prev && sdata !== sd_prev)
                chk(fell_last, "R2", "sdata change follows bit clock fall", fell_last, 1);
            fell_last = fell_now;
            mb_prev   = bclk_out;
        end
        sd_prev = sdata;
        pd_prev = pd_b;
        if (!obs_prev && obs_b) begin
            observe();
            just_obs = 1;
        end
        obs_prev = obs_b;
    endtask

    task automatic run_slots(input int n);
        int k = 0;
        while (k < n) begin
            tick();
            if (just_obs) k++;
        end
    endtask

    task automatic until_slot(input int s);
        do tick(); while (!(just_obs && m_slot == s));
    endtask

    task automatic set_pd(input logic v);
        pd_b = v;
        if (v) begin
            m_ready = 0;
            m_rise  = 0;
        end
    endtask

    task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
        q_l.push_back(l);
        q_r.push_back(r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdata == 0 && ready == 0 && bclk_out == 0 && ws_out == 0, "R10",
            "reset state", {sdata, ready, bclk_out, ws_out}, 0);

        // held in power-down: line and flag stay low
        run_slots(80);

        // release power-down; mute window, then standard placement
        push(24'hFFFFFF, 24'h000000);
        push(24'h800000, 24'h000001);
        push(24'hA5A5A5, 24'h5A5A5A);
        push(24'h123456, 24'hABCDEF);
        until_slot(5);
        set_pd(1'b0);
        run_slots(64 * 5);
        push(24'hFFFFFF, 24'hFFFFFF);
        push(24'h000001, 24'h800000);
        push(24'hC3C3C3, 24'h3C3C3C);
        run_slots(64 * 5);
        // no new sample: repeat the last pair
        run_slots(64 * 2);

        // left-justified placement
        until_slot(5);
        fmt_b = 1'b1;
        push(24'hFFFFFF, 24'h000000);
        push(24'h800001, 24'h7FFFFE);
        push(24'h0F0F0F, 24'hF0F0F0);
        run_slots(64 * 5);

        // second power-down restarts the mute window
        until_slot(5);
        set_pd(1'b1);
        run_slots(64 * 2);
        until_slot(5);
        set_pd(1'b0);
        push(24'h555555, 24'hAAAAAA);
        run_slots(64 * 5);

        // slave mode with standard placement
        until_slot(5);
        set_pd(1'b1);
        master_b = 1'b0;
        fmt_b    = 1'b0;
        run_slots(40);
        until_slot(5);
        set_pd(1'b0);
        push(24'hFEDCBA, 24'h13579B);
        push(24'h800000, 24'h000001);
        run_slots(64 * 6);
        until_slot(5);
        fmt_b = 1'b1;
        push(24'hA5A5A5, 24'h000F00);
        run_slots(64 * 3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule